// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block is a bus master that reaches registers hidden behind a mailbox. A requester presents one access at a time: a direction flag, a target address and, for writes, a data word. The sequencer turns that into a fixed series of single-beat accesses on a memory-mapped register bus. It loads the mailbox address and data registers and writes a command code. It polls an acknowledge register, fetches the result when needed, and always ends by returning the mailbox command register to its idle code.

Every wait is bounded by a cycle-count timeout, and polls are spaced by a fixed gap. The response reports a status code, a warning bit for a command register that was not idle on entry, and the read data. The register offsets, the three command codes, the acknowledge mask, the timeout and the poll gap are all parameters.

Top module: `ind_reg_seq`

## Requirements
- R1: `req_ready_o` is high only while no transaction is in progress. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` then stays low until the response. The response is a single-cycle `rsp_valid_o` pulse, and `req_ready_o` is high again in the following cycle.
- R2: The first bus access of every transaction is a read of the command register. If the value read differs from the idle code, `rsp_warn_o` is 1 in the response, but the transaction goes on unchanged. Otherwise `rsp_warn_o` is 0.
- R3: A write request issues three bus writes in this order: the request data to the write-data register, the request address (zero-extended) to the address register, and the write code to the command register.
- R4: A read request issues two bus writes in this order: the request address to the address register, then the read code to the command register.
- R5: After the command write, the acknowledge register is read repeatedly. The poll succeeds when every bit set in the acknowledge mask is also set in the value read; other bits are ignored. After a failed poll, the block waits POLL_GAP idle cycles before the next poll. The phase gives up when a poll fails and at least TIMEOUT_CYC cycles have passed since the phase began. With zero bus wait states this gives at most (TIMEOUT_CYC+POLL_GAP)/(POLL_GAP+1)+1 polls, using integer division.
- R6: The read-data register is read exactly once, and only in a read transaction whose acknowledge poll succeeded. `rsp_rdata_o` carries that value only when the status is ok; otherwise it is zero. It is always zero for write requests.
- R7: After the acknowledge phase, whether it succeeded or timed out, the idle code is written to the command register. The command register is then polled until it reads back the idle code, with the same gap and timeout rule as R5.
- R8: `rsp_status_o` is 0 for ok, 1 for acknowledge timeout and 2 for idle timeout. An acknowledge timeout is reported even if the idle phase also timed out. The code 3 never appears.
- R9: While `bus_valid_o` is high and `bus_ready_i` is low, `bus_valid_o` stays high and the address, direction and write data stay unchanged.
- R10: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `bus_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer free to accept a request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | REQ_AW | Target register address behind the mailbox |
| req_wdata_i | input | DATA_W | Data for a write request |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 2 | 0 ok, 1 acknowledge timeout, 2 idle timeout |
| rsp_warn_o | output | 1 | Command register was not idle on entry |
| rsp_rdata_o | output | DATA_W | Read result, zero unless ok read |
| bus_valid_o | output | 1 | Bus access request |
| bus_ready_i | input | 1 | Bus access completes this cycle |
| bus_write_o | output | 1 | 1 for bus write |
| bus_addr_o | output | BUS_AW | Mailbox register offset |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data, valid with bus_ready_i |

## Verification
The bench builds the block with TIMEOUT_CYC=12 and POLL_GAP=2, which allows five polls per phase when the bus has no wait states. A mailbox model delays the acknowledge and the idle readback by 0 to 6 polls each, for both directions. The sweep therefore covers success at every poll position, a timeout in either phase, and both at once. Further runs add bus wait states to exercise the hold rule, and start with a stale command register to exercise the entry warning.

// File: rtl/ind_reg_pkg.sv
package ind_reg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_WDAT,
    ST_ADDR,
    ST_CMD,
    ST_ACK,
    ST_ACK_GAP,
    ST_DATA,
    ST_IDLE_CMD,
    ST_IDLE_POLL,
    ST_IDLE_GAP,
    ST_RESP
  } seq_state_e;

  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_ACK_TO  = 2'd1,
    RSP_IDLE_TO = 2'd2
  } rsp_status_e;

endpackage

// File: rtl/ind_poll_timer.sv
module ind_poll_timer #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int POLL_GAP    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic gap_i,
  output logic expired_o,
  output logic gap_done_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] T_LIM = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  // saturating phase-elapsed counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (run_i && cnt_q != T_LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= T_LIM);

  generate
    if (POLL_GAP > 0) begin : g_gap
      localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
      localparam logic [GW-1:0] G_LIM = GW'(POLL_GAP - 1);
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   gap_q <= '0;
        else if (gap_i && !gap_done_o) gap_q <= gap_q + 1'b1;
        else                           gap_q <= '0;
      end
      assign gap_done_o = (gap_q == G_LIM);
    end else begin : g_nogap
      logic unused_gap;
      assign unused_gap = gap_i;
      assign gap_done_o = 1'b1;
    end
  endgenerate

  AST_TMR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !expired_o); // R5

endmodule

// File: rtl/ind_seq_ctrl.sv
module ind_seq_ctrl
  import ind_reg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                REQ_AW    = 16,
  parameter int                BUS_AW    = 8,
  parameter logic [BUS_AW-1:0] OFS_CMD   = 'h00,
  parameter logic [BUS_AW-1:0] OFS_ACK   = 'h04,
  parameter logic [BUS_AW-1:0] OFS_ADDR  = 'h08,
  parameter logic [BUS_AW-1:0] OFS_RDATA = 'h0C,
  parameter logic [BUS_AW-1:0] OFS_WDATA = 'h10,
  parameter logic [DATA_W-1:0] CMD_IDLE  = 'h0,
  parameter logic [DATA_W-1:0] CMD_READ  = 'h1,
  parameter logic [DATA_W-1:0] CMD_WRITE = 'h2,
  parameter logic [DATA_W-1:0] ACK_MASK  = 'h3,
  parameter int                POLL_GAP  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [REQ_AW-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic              rsp_warn_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_write_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              tmr_clr_o,
  output logic              tmr_run_o,
  output logic              tmr_gap_o,
  input  logic              tmr_expired_i,
  input  logic              tmr_gap_done_i
);
  localparam bit GAP_EN = (POLL_GAP > 0);

  seq_state_e        state_q, state_d;
  logic              wr_q, warn_q, ack_to_q, idle_to_q;
  logic [REQ_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  rsp_status_e       status;

  logic bus_done, ack_hit, idle_hit;
  assign bus_done = bus_valid_o && bus_ready_i;
  assign ack_hit  = ((bus_rdata_i & ACK_MASK) == ACK_MASK);
  assign idle_hit = (bus_rdata_i == CMD_IDLE);

  always_comb begin
    state_d     = state_q;
    tmr_clr_o   = 1'b0;
    bus_valid_o = 1'b0;
    bus_write_o = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_ENTRY;
      ST_ENTRY: begin
        bus_valid_o = 1'b1;
        bus_addr_o  = OFS_CMD;
        if (bus_done) state_d = wr_q ? ST_WDAT : ST_ADDR;
      end
      ST_WDAT: begin
        bus_valid_o = 1'b1;
        bus_write_o = 1'b1;
        bus_addr_o  = OFS_WDATA;
        bus_wdata_o = wdata_q;
        if (bus_done) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        bus_valid_o = 1'b1;
        bus_write_o = 1'b1;
        bus_addr_o  = OFS_ADDR;
        bus_wdata_o = DATA_W'(addr_q);
        if (bus_done) state_d = ST_CMD;
      end
      ST_CMD: begin
        bus_valid_o = 1'b1;
        bus_write_o = 1'b1;
        bus_addr_o  = OFS_CMD;
        bus_wdata_o = wr_q ? CMD_WRITE : CMD_READ;
        if (bus_done) begin
          state_d   = ST_ACK;
          tmr_clr_o = 1'b1;
        end
      end
      ST_ACK: begin
        bus_valid_o = 1'b1;
        bus_addr_o  = OFS_ACK;
        if (bus_done) begin
          if (ack_hit)            state_d = wr_q ? ST_IDLE_CMD : ST_DATA;
          else if (tmr_expired_i) state_d = ST_IDLE_CMD;
          else                    state_d = GAP_EN ? ST_ACK_GAP : ST_ACK;
        end
      end
      ST_ACK_GAP: if (tmr_gap_done_i) state_d = ST_ACK;
      ST_DATA: begin
        bus_valid_o = 1'b1;
        bus_addr_o  = OFS_RDATA;
        if (bus_done) state_d = ST_IDLE_CMD;
      end
      ST_IDLE_CMD: begin
        bus_valid_o = 1'b1;
        bus_write_o = 1'b1;
        bus_addr_o  = OFS_CMD;
        bus_wdata_o = CMD_IDLE;
        if (bus_done) begin
          state_d   = ST_IDLE_POLL;
          tmr_clr_o = 1'b1;
        end
      end
      ST_IDLE_POLL: begin
        bus_valid_o = 1'b1;
        bus_addr_o  = OFS_CMD;
        if (bus_done) begin
          if (idle_hit || tmr_expired_i) state_d = ST_RESP;
          else                           state_d = GAP_EN ? ST_IDLE_GAP : ST_IDLE_POLL;
        end
      end
      ST_IDLE_GAP: if (tmr_gap_done_i) state_d = ST_IDLE_POLL;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      warn_q    <= 1'b0;
      ack_to_q  <= 1'b0;
      idle_to_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        wr_q      <= req_write_i;
        addr_q    <= req_addr_i;
        wdata_q   <= req_wdata_i;
        rdata_q   <= '0;
        warn_q    <= 1'b0;
        ack_to_q  <= 1'b0;
        idle_to_q <= 1'b0;
      end
      if (state_q == ST_ENTRY && bus_done) warn_q <= !idle_hit;
      if (state_q == ST_ACK && bus_done && !ack_hit && tmr_expired_i) ack_to_q <= 1'b1;
      if (state_q == ST_DATA && bus_done) rdata_q <= bus_rdata_i;
      if (state_q == ST_IDLE_POLL && bus_done && !idle_hit && tmr_expired_i) idle_to_q <= 1'b1;
    end
  end

  assign tmr_run_o = (state_q == ST_ACK) || (state_q == ST_ACK_GAP) ||
                     (state_q == ST_IDLE_POLL) || (state_q == ST_IDLE_GAP);
  assign tmr_gap_o = (state_q == ST_ACK_GAP) || (state_q == ST_IDLE_GAP);

  // ack timeout outranks idle timeout
  assign status       = ack_to_q ? RSP_ACK_TO : (idle_to_q ? RSP_IDLE_TO : RSP_OK);
  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_status_o = status;
  assign rsp_warn_o   = warn_q;
  assign rsp_rdata_o  = (status == RSP_OK) ? rdata_q : '0;

  AST_ONE_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R1
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o); // R1
  AST_STATUS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_status_o != 2'b11); // R8
  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) &&
    $stable(bus_write_o) && $stable(bus_wdata_o)); // R9
  AST_FREE_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_valid_o && !rsp_valid_o); // R10

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq #(
  parameter int                DATA_W      = 32,
  parameter int                REQ_AW      = 16,
  parameter int                BUS_AW      = 8,
  parameter logic [BUS_AW-1:0] OFS_CMD     = 'h00,
  parameter logic [BUS_AW-1:0] OFS_ACK     = 'h04,
  parameter logic [BUS_AW-1:0] OFS_ADDR    = 'h08,
  parameter logic [BUS_AW-1:0] OFS_RDATA   = 'h0C,
  parameter logic [BUS_AW-1:0] OFS_WDATA   = 'h10,
  parameter logic [DATA_W-1:0] CMD_IDLE    = 'h0,
  parameter logic [DATA_W-1:0] CMD_READ    = 'h1,
  parameter logic [DATA_W-1:0] CMD_WRITE   = 'h2,
  parameter logic [DATA_W-1:0] ACK_MASK    = 'h3,
  parameter int                TIMEOUT_CYC = 1000,
  parameter int                POLL_GAP    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [REQ_AW-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic              rsp_warn_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_write_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic tmr_clr, tmr_run, tmr_gap, tmr_expired, tmr_gap_done;

  ind_seq_ctrl #(
    .DATA_W(DATA_W), .REQ_AW(REQ_AW), .BUS_AW(BUS_AW),
    .OFS_CMD(OFS_CMD), .OFS_ACK(OFS_ACK), .OFS_ADDR(OFS_ADDR),
    .OFS_RDATA(OFS_RDATA), .OFS_WDATA(OFS_WDATA),
    .CMD_IDLE(CMD_IDLE), .CMD_READ(CMD_READ), .CMD_WRITE(CMD_WRITE),
    .ACK_MASK(ACK_MASK), .POLL_GAP(POLL_GAP)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_status_o, .rsp_warn_o, .rsp_rdata_o,
    .bus_valid_o, .bus_ready_i, .bus_write_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .tmr_clr_o(tmr_clr), .tmr_run_o(tmr_run), .tmr_gap_o(tmr_gap),
    .tmr_expired_i(tmr_expired), .tmr_gap_done_i(tmr_gap_done)
  );

  ind_poll_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .POLL_GAP(POLL_GAP)
  ) u_timer (
    .clk_i, .rst_ni,
    .clr_i(tmr_clr), .run_i(tmr_run), .gap_i(tmr_gap),
    .expired_o(tmr_expired), .gap_done_o(tmr_gap_done)
  );

endmodule

// File: tb/tb_ind_reg_seq.sv
`timescale 1ns/1ps
module tb_ind_reg_seq;
  localparam int DW = 32, BAW = 8, RAW = 12, TMO = 12, GAP = 2;
  localparam int PMAX = (TMO + GAP) / (GAP + 1) + 1;
  localparam logic [BAW-1:0] A_CMD = 8'h00, A_ACK = 8'h04, A_ADDR = 8'h08,
                             A_RDAT = 8'h0C, A_WDAT = 8'h10;
  localparam logic [DW-1:0] C_IDLE = 32'h0, C_RD = 32'h1, C_WR = 32'h2, AMASK = 32'h3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [RAW-1:0] req_addr = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_warn, bus_valid, bus_ready, bus_write;
  logic [1:0] rsp_status;
  logic [DW-1:0] rsp_rdata, bus_wdata, bus_rdata;
  logic [BAW-1:0] bus_addr;

  always #4 clk = ~clk;

  ind_reg_seq #(
    .DATA_W(DW), .REQ_AW(RAW), .BUS_AW(BAW),
    .OFS_CMD(A_CMD), .OFS_ACK(A_ACK), .OFS_ADDR(A_ADDR), .OFS_RDATA(A_RDAT), .OFS_WDATA(A_WDAT),
    .CMD_IDLE(C_IDLE), .CMD_READ(C_RD), .CMD_WRITE(C_WR), .ACK_MASK(AMASK),
    .TIMEOUT_CYC(TMO), .POLL_GAP(GAP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_warn_o(rsp_warn), .rsp_rdata_o(rsp_rdata),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_write_o(bus_write),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  int checks = 0, fails = 0, cyc = 0;

  // knobs, driven only by the initial block
  int knob_ackd = 0, knob_idled = 0, knob_lat = 0;
  logic [DW-1:0] knob_entry = C_IDLE;

  // mailbox model, driven only by the posedge block
  logic [DW-1:0] m_cmd = C_IDLE, m_cmd_old = C_IDLE, m_addr = '0;
  bit m_pend = 1'b0, got_rsp = 1'b0;
  int m_ack_cnt = 0, m_idle_cnt = 0, wait_cnt = 0, log_n = 0;
  logic [1:0] got_status = '0;
  logic got_warn = 1'b0;
  logic [DW-1:0] got_rdata = '0;
  bit log_we [32];
  logic [BAW-1:0] log_ad [32];
  logic [DW-1:0] log_dt [32];

  function automatic logic [DW-1:0] rd_fn(input logic [DW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  assign bus_ready = bus_valid && (wait_cnt >= knob_lat);

  always_comb begin
    case (bus_addr)
      A_CMD:   bus_rdata = (m_pend && m_idle_cnt < knob_idled) ? m_cmd_old : m_cmd;
      A_ACK:   bus_rdata = (m_ack_cnt >= knob_ackd) ? 32'h0000_0F03 : 32'h0000_0101;
      A_RDAT:  bus_rdata = rd_fn(m_addr);
      default: bus_rdata = 32'hDEAD_0000;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req_valid && req_ready) begin
      log_n   <= 0;
      m_pend  <= 1'b0;
      m_cmd   <= knob_entry;
      got_rsp <= 1'b0;
    end
    if (bus_valid && !bus_ready) wait_cnt <= wait_cnt + 1;
    else                         wait_cnt <= 0;
    if (bus_valid && bus_ready) begin
      if (log_n < 32) begin
        log_we[log_n] <= bus_write;
        log_ad[log_n] <= bus_addr;
        log_dt[log_n] <= bus_wdata;
      end
      log_n <= log_n + 1;
      if (bus_write) begin
        if (bus_addr == A_CMD) begin
          if (bus_wdata == C_IDLE) begin
            m_cmd_old <= m_cmd; m_cmd <= bus_wdata; m_pend <= 1'b1; m_idle_cnt <= 0;
          end else begin
            m_cmd <= bus_wdata; m_pend <= 1'b0; m_ack_cnt <= 0;
          end
        end else if (bus_addr == A_ADDR) m_addr <= bus_wdata;
      end else begin
        if (bus_addr == A_ACK) m_ack_cnt <= m_ack_cnt + 1;
        if (bus_addr == A_CMD && m_pend) m_idle_cnt <= m_idle_cnt + 1;
      end
    end
    if (rsp_valid) begin
      got_rsp <= 1'b1; got_status <= rsp_status; got_warn <= rsp_warn; got_rdata <= rsp_rdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  bit e_we [32];
  logic [BAW-1:0] e_ad [32];
  logic [DW-1:0] e_dt [32];
  int e_n = 0;

  function automatic void push(input bit we, input logic [BAW-1:0] ad, input logic [DW-1:0] dt);
    e_we[e_n] = we; e_ad[e_n] = ad; e_dt[e_n] = dt; e_n++;
  endfunction

  task automatic run_txn(input bit wr, input logic [RAW-1:0] a, input logic [DW-1:0] d,
                         input int ackd, input int idled, input int lat, input logic [DW-1:0] entry);
    bit ack_ok, idle_ok, seq_ok;
    int na, ni, bad;
    logic [1:0] exp_st;
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    knob_ackd = ackd; knob_idled = idled; knob_lat = lat; knob_entry = entry;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 busy after accept", {31'b0, req_ready}, 32'h0);
    while (!got_rsp) @(negedge clk);
    chk(req_ready, "R1 free after response", {31'b0, req_ready}, 32'h1);

    ack_ok  = ackd < PMAX;
    idle_ok = idled < PMAX;
    na = ack_ok ? ackd + 1 : PMAX;
    ni = idle_ok ? idled + 1 : PMAX;
    e_n = 0;
    push(1'b0, A_CMD, '0);
    if (wr) push(1'b1, A_WDAT, d);
    push(1'b1, A_ADDR, DW'(a));
    push(1'b1, A_CMD, wr ? C_WR : C_RD);
    for (int k = 0; k < na; k++) push(1'b0, A_ACK, '0);
    if (!wr && ack_ok) push(1'b0, A_RDAT, '0);
    push(1'b1, A_CMD, C_IDLE);
    for (int k = 0; k < ni; k++) push(1'b0, A_CMD, '0);

    seq_ok = (log_n == e_n);
    bad = -1;
    for (int k = 0; k < e_n && k < log_n; k++)
      if (log_we[k] != e_we[k] || log_ad[k] != e_ad[k] || (e_we[k] && log_dt[k] != e_dt[k])) begin
        if (bad < 0) bad = k;
        seq_ok = 1'b0;
      end
    if (bad >= 0)
      chk(1'b0, "R2 R3 R4 R5 R7 bus sequence", {24'b0, log_ad[bad]}, {24'b0, e_ad[bad]});
    else
      chk(seq_ok, "R2 R3 R4 R5 R7 bus access count", log_n, e_n);

    exp_st = !ack_ok ? 2'd1 : (!idle_ok ? 2'd2 : 2'd0);
    exp_rd = (!wr && exp_st == 2'd0) ? rd_fn(DW'(a)) : '0;
    chk(got_status == exp_st, "R8 status", {30'b0, got_status}, {30'b0, exp_st});
    chk(got_rdata == exp_rd, "R6 read data", got_rdata, exp_rd);
    chk(got_warn == (entry != C_IDLE), "R2 entry warning", {31'b0, got_warn}, {31'b0, entry != C_IDLE});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R10 reset ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid === 1'b0, "R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(bus_valid === 1'b0, "R10 reset bus_valid", {31'b0, bus_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && bus_valid === 1'b0, "R10 idle after reset", {31'b0, req_ready}, 32'h1);

    for (int w = 0; w < 2; w++)
      for (int ad = 0; ad <= PMAX + 1; ad++)
        for (int id = 0; id <= PMAX + 1; id++)
          run_txn(w[0], RAW'(12'h0A5 + ad * 37 + id * 5 + w), 32'hC0DE_0000 ^ (ad << 8) ^ id,
                  ad, id, 0, C_IDLE);

    // stale command register on entry
    run_txn(1'b0, 12'h123, 32'h0, 1, 0, 0, C_WR);
    run_txn(1'b1, 12'h456, 32'hFACE_B00C, 0, 2, 0, 32'h77);
    // bus wait states
    run_txn(1'b0, 12'h7FF, 32'h0, 0, 0, 1, C_IDLE);
    run_txn(1'b1, 12'hABC, 32'h1234_5678, 0, 0, 3, C_IDLE);
    run_txn(1'b0, 12'h001, 32'h0, 0, 0, 3, C_RD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule